// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a memory array that has two independent access ports, called left and right. On every cycle it compares the two port addresses while both ports are enabled. When both point at the same word, it names exactly one port as the loser. It raises an active-low busy line towards that port and withholds the loser's write permit. The port that asked first keeps access. If both ports arrive in the same cycle, the left port wins. Reads are not affected; only the write permit is gated.

A request arrives when a port's enable rises or when its address changes while it is enabled. Per-port history registers record the previous enable and address, so arrival order is judged from the current inputs and the state captured at the last clock edge. The busy lines and write permits follow the inputs combinationally. The winner keeps access until its own request ends or moves, and the ownership is then decided again from the inputs of the next cycle.

A mode input picks the role. As master, the block drives both busy lines with push-pull drivers and enables them through a drive-enable output. As slave, it drives neither busy line. It holds its busy outputs high, and an external master's busy inputs decide which port's writes are blocked.

Top module: `dpca_top`

## Requirements
- R1: In master mode, if either enable is low or the two addresses differ, both busy outputs are high.
- R2: In master mode, with both ports enabled on the same address, the port whose request arrived in a later cycle sees busy low. The earlier port keeps busy high.
- R3: When both requests arrive in the same cycle on the same address, the right port sees busy low and the left port keeps access.
- R4: The two busy outputs are never low in the same cycle.
- R5: A port's write permit is high exactly when its enable and write request are high and that port is not busy. Busy is the port's own busy output in master mode and its busy input (low = blocked) in slave mode.
- R6: The winner keeps access for as long as its enable stays high and its address stays unchanged, even if the other port leaves and comes back. When the winner's address changes, the next cycle judges arrival afresh.
- R7: In slave mode both busy outputs are high regardless of the addresses, and each port's writes are blocked only by its own busy input.
- R8: The busy drive-enable output is high in master mode and low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master (drives busy), 0 = slave (accepts busy) |
| left_en | input | 1 | Left port enable, active high |
| left_we | input | 1 | Left port write request, active high |
| left_addr | input | ADDR_W | Left port address |
| right_en | input | 1 | Right port enable, active high |
| right_we | input | 1 | Right port write request, active high |
| right_addr | input | ADDR_W | Right port address |
| busy_in_left_n | input | 1 | Slave mode: external busy for the left port, active low |
| busy_in_right_n | input | 1 | Slave mode: external busy for the right port, active low |
| busy_out_left_n | output | 1 | Busy towards the left port, active low |
| busy_out_right_n | output | 1 | Busy towards the right port, active low |
| busy_drive_en | output | 1 | Enables the push-pull busy drivers |
| left_wr_ok | output | 1 | Write permit for the left port |
| right_wr_ok | output | 1 | Write permit for the right port |

## Verification
The assertions check four things on every cycle. At most one busy line is low, and a busy port never has a write permit. Slave mode keeps the busy outputs high, and a mismatch or a disabled port leaves both lines idle. Two further assertions check that a simultaneous arrival goes to the left port and that an undisturbed winner keeps its access. Arrival order over many cycles can only be shown by the bench scenarios. These cover the right port arriving first, the winner moving away and back, the loser re-arriving, and mode changes under random traffic. A reference model based on time stamps compares every output on every clock.

// File: rtl/dpca_pkg.sv
// Shared types for the dual-port contention arbiter.
package dpca_pkg;

    // Which port currently owns a contended address.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpca_port_track.sv
// Per-port request history.
// Flags a fresh request: the enable has just risen, or the address moved
// while the port stayed enabled. Assumes the inputs are synchronous to clk.
module dpca_port_track #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);

    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture the previous cycle's enable and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // A request is new when it was absent or pointed elsewhere last cycle.
    always_comb begin
        fresh = en && (!en_q || (addr != addr_q));
    end

endmodule

// File: rtl/dpca_owner.sv
// Ownership decision for a contended address.
// Keeps the current owner while its request is unchanged. Otherwise the
// older request wins, and a tie goes to the left port.
// Assumes the fresh flags come from dpca_port_track.
module dpca_owner
    import dpca_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_fresh,
    input  logic              r_fresh,
    output logic              match,
    output owner_e            owner
);

    owner_e owner_q;
    logic   held;

    // Detect contention and decide who owns the shared word.
    always_comb begin
        match = l_en && r_en && (l_addr == r_addr);
        held  = match && (((owner_q == OWN_LEFT) && !l_fresh) ||
                          ((owner_q == OWN_RIGHT) && !r_fresh));
        if (!match)
            owner = OWN_NONE;
        else if (held)
            owner = owner_q;
        else if (l_fresh && !r_fresh)
            owner = OWN_RIGHT;
        else
            owner = OWN_LEFT;
    end

    // Remember the owner so that it is kept on later cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner;
    end

    // R3: a simultaneous arrival goes to the left port.
    a_r3_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
        (match && l_fresh && r_fresh) |-> (owner == OWN_LEFT));

endmodule

// File: rtl/dpca_wr_gate.sv
// Per-port busy driver and write gate.
// In master mode it drives busy from the local arbitration result. In slave
// mode it holds busy high and blocks writes from the external busy input.
module dpca_wr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic lost,
    input  logic busy_in_n,
    input  logic en,
    input  logic we,
    output logic busy_out_n,
    output logic wr_ok
);

    logic blocked;

    // Select the busy source by mode and gate the write request.
    always_comb begin
        busy_out_n = master_mode ? !lost : 1'b1;
        blocked    = master_mode ? lost : !busy_in_n;
        wr_ok      = en && we && !blocked;
    end

    // R5: a port that sees busy never gets a write permit.
    a_r5_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_out_n |-> !wr_ok);

    // R7: a slave never asserts busy on its own outputs.
    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> busy_out_n);

endmodule

// File: rtl/dpca_top.sv
// Dual-port address contention arbiter, top level.
// Tracks each port's request age, awards a contended address to the older
// request, and drives busy and the write permits by the selected mode.
module dpca_top
    import dpca_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              left_en,
    input  logic              left_we,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en,
    input  logic              right_we,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              busy_in_left_n,
    input  logic              busy_in_right_n,
    output logic              busy_out_left_n,
    output logic              busy_out_right_n,
    output logic              busy_drive_en,
    output logic              left_wr_ok,
    output logic              right_wr_ok
);

    logic [NUM_PORTS-1:0]             p_en;
    logic [NUM_PORTS-1:0]             p_we;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [NUM_PORTS-1:0]             p_fresh;
    logic [NUM_PORTS-1:0]             p_lost;
    logic [NUM_PORTS-1:0]             p_bin_n;
    logic [NUM_PORTS-1:0]             p_bout_n;
    logic [NUM_PORTS-1:0]             p_wr;
    logic                             match;
    owner_e                           owner;

    // Gather the port signals into arrays and spread the results back out.
    always_comb begin
        p_en[PORT_L]     = left_en;
        p_en[PORT_R]     = right_en;
        p_we[PORT_L]     = left_we;
        p_we[PORT_R]     = right_we;
        p_addr[PORT_L]   = left_addr;
        p_addr[PORT_R]   = right_addr;
        p_bin_n[PORT_L]  = busy_in_left_n;
        p_bin_n[PORT_R]  = busy_in_right_n;
        p_lost[PORT_L]   = (owner == OWN_RIGHT);
        p_lost[PORT_R]   = (owner == OWN_LEFT);
        busy_out_left_n  = p_bout_n[PORT_L];
        busy_out_right_n = p_bout_n[PORT_R];
        left_wr_ok       = p_wr[PORT_L];
        right_wr_ok      = p_wr[PORT_R];
        busy_drive_en    = master_mode;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpca_port_track #(.ADDR_W(ADDR_W)) i_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (p_en[g]),
            .addr  (p_addr[g]),
            .fresh (p_fresh[g])
        );

        dpca_wr_gate i_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .lost        (p_lost[g]),
            .busy_in_n   (p_bin_n[g]),
            .en          (p_en[g]),
            .we          (p_we[g]),
            .busy_out_n  (p_bout_n[g]),
            .wr_ok       (p_wr[g])
        );
    end

    dpca_owner #(.ADDR_W(ADDR_W)) i_owner (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_en    (left_en),
        .r_en    (right_en),
        .l_addr  (left_addr),
        .r_addr  (right_addr),
        .l_fresh (p_fresh[PORT_L]),
        .r_fresh (p_fresh[PORT_R]),
        .match   (match),
        .owner   (owner)
    );

    // R4: at most one busy line is low.
    a_r4_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_out_left_n && !busy_out_right_n));

    // R1: without contention, both busy lines stay idle.
    a_r1_idle_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_en || !right_en || (left_addr != right_addr)) |->
        (busy_out_left_n && busy_out_right_n));

    // R6: an undisturbed left winner keeps access on the next cycle.
    a_r6_winner_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && !$past(busy_out_right_n) &&
         left_en && $past(left_en) && (left_addr == $past(left_addr)) &&
         right_en && (right_addr == left_addr)) |-> !busy_out_right_n);

    // R8: the busy drivers are enabled only in master mode.
    a_r8_drive_mode: assert property (@(posedge clk) disable iff (!rst_n)
        busy_drive_en == master_mode);

endmodule

// File: tb/test_dpca_top.sv
// Bench for dpca_top: a time-stamp reference model compared on every clock.
module test_dpca_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              master_mode;
    logic              left_en, left_we, right_en, right_we;
    logic [ADDR_W-1:0] left_addr, right_addr;
    logic              busy_in_left_n, busy_in_right_n;
    logic              busy_out_left_n, busy_out_right_n, busy_drive_en;
    logic              left_wr_ok, right_wr_ok;

    int n_cmp  = 0;
    int n_fail = 0;

    // Reference model state.
    int                m_cyc    = 0;
    int                m_lstamp = 0;
    int                m_rstamp = 0;
    logic              m_pl_en  = 1'b0;
    logic              m_pr_en  = 1'b0;
    logic [ADDR_W-1:0] m_pl_a   = '0;
    logic [ADDR_W-1:0] m_pr_a   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpca_top #(.ADDR_W(ADDR_W)) i_dpca_top (
        .clk              (clk),
        .rst_n            (rst_n),
        .master_mode      (master_mode),
        .left_en          (left_en),
        .left_we          (left_we),
        .left_addr        (left_addr),
        .right_en         (right_en),
        .right_we         (right_we),
        .right_addr       (right_addr),
        .busy_in_left_n   (busy_in_left_n),
        .busy_in_right_n  (busy_in_right_n),
        .busy_out_left_n  (busy_out_left_n),
        .busy_out_right_n (busy_out_right_n),
        .busy_drive_en    (busy_drive_en),
        .left_wr_ok       (left_wr_ok),
        .right_wr_ok      (right_wr_ok)
    );

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, m_cyc);
        end
    endtask

    // Run one cycle: check outputs mid-cycle, then update the model at the edge.
    task automatic step(input string tag);
        logic mat, lnew, rnew, lb, rb;
        int   ls, rs;
        #(CLK_PERIOD/4);
        lnew = left_en && (!m_pl_en || left_addr != m_pl_a);
        rnew = right_en && (!m_pr_en || right_addr != m_pr_a);
        ls   = lnew ? m_cyc : m_lstamp;
        rs   = rnew ? m_cyc : m_rstamp;
        mat  = left_en && right_en && (left_addr == right_addr);
        lb   = 1'b0;
        rb   = 1'b0;
        if (mat) begin
            if (ls <= rs) rb = 1'b1;
            else          lb = 1'b1;
        end
        cmp(tag, "busy_out_left_n",  busy_out_left_n,  master_mode ? !lb : 1'b1);
        cmp(tag, "busy_out_right_n", busy_out_right_n, master_mode ? !rb : 1'b1);
        cmp(tag, "left_wr_ok",  left_wr_ok,
            left_en && left_we && !(master_mode ? lb : !busy_in_left_n));
        cmp(tag, "right_wr_ok", right_wr_ok,
            right_en && right_we && !(master_mode ? rb : !busy_in_right_n));
        cmp("R8", "busy_drive_en", busy_drive_en, master_mode);
        cmp("R4", "not both busy", !(!busy_out_left_n && !busy_out_right_n), 1'b1);
        @(posedge clk);
        if (rst_n) begin
            if (lnew) m_lstamp = m_cyc;
            if (rnew) m_rstamp = m_cyc;
            m_pl_en = left_en;
            m_pr_en = right_en;
            m_pl_a  = left_addr;
            m_pr_a  = right_addr;
        end else begin
            m_pl_en = 1'b0;
            m_pr_en = 1'b0;
            m_pl_a  = '0;
            m_pr_a  = '0;
        end
        m_cyc++;
        @(negedge clk);
    endtask

    task automatic drive(input logic le, input logic [ADDR_W-1:0] la, input logic lw,
                         input logic re, input logic [ADDR_W-1:0] ra, input logic rw);
        left_en = le; left_addr = la; left_we = lw;
        right_en = re; right_addr = ra; right_we = rw;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        master_mode = 1'b1;
        busy_in_left_n = 1'b1;
        busy_in_right_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        // Reset state: idle busy lines, no permits (R1).
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        // R1: different addresses, then one port disabled on a shared address.
        drive(1, 16'h0010, 1, 1, 16'h0020, 1); step("R1"); step("R1");
        drive(1, 16'h0030, 1, 0, 16'h0030, 1); step("R1");
        drive(0, 16'h0030, 1, 1, 16'h0030, 1); step("R1");
        // R2: right is already on 0x30, left arrives later and loses (R5 writes).
        drive(1, 16'h0030, 1, 1, 16'h0030, 1); step("R2"); step("R5"); step("R2");
        // R2: reverse order, left first then right arrives.
        drive(0, 0, 0, 0, 0, 0); step("R2");
        drive(1, 16'h0044, 1, 0, 0, 0); step("R2");
        drive(1, 16'h0044, 1, 1, 16'h0044, 1); step("R2"); step("R5");
        // R3: both arrive together on the same address.
        drive(0, 0, 0, 0, 0, 0); step("R3");
        drive(1, 16'hFFFE, 1, 1, 16'hFFFE, 1); step("R3"); step("R3");
        // R6: the loser leaves and returns; the left winner keeps access.
        drive(1, 16'hFFFE, 1, 1, 16'hFFFF, 1); step("R6");
        drive(1, 16'hFFFE, 1, 1, 16'hFFFE, 1); step("R6"); step("R6");
        // R6: the winner moves away and back, so the right request is now older.
        drive(1, 16'h0001, 1, 1, 16'hFFFE, 1); step("R6");
        drive(1, 16'hFFFE, 1, 1, 16'hFFFE, 1); step("R6"); step("R6");
        // R7: slave mode: no busy out, writes gated by the busy inputs only.
        master_mode = 1'b0;
        drive(1, 16'h0005, 1, 1, 16'h0005, 1); step("R7");
        busy_in_left_n = 1'b0; step("R7");
        busy_in_left_n = 1'b1; busy_in_right_n = 1'b0; step("R7");
        busy_in_right_n = 1'b1; master_mode = 1'b1; step("R8");
        // Random traffic on a small address range for frequent contention.
        for (int i = 0; i < 600; i++) begin
            master_mode     = ($urandom_range(0, 7) != 0);
            busy_in_left_n  = ($urandom_range(0, 3) != 0);
            busy_in_right_n = ($urandom_range(0, 3) != 0);
            drive($urandom_range(0, 4) != 0, 16'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 4) != 0, 16'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            step("R2");
        end
        finish_run();
    end

endmodule